// File: doc/BRIEF.md
# Receive Buffer Pool and Descriptor Queue

This block keeps track of which packet buffers a full-speed USB device may fill next, and of the packets that have already landed in them. Software hands free 5-bit buffer identifiers to the block through two separate pools: one feeds SETUP packets and the other feeds OUT packets. When the serial receive logic sees a packet begin, it asks the block for a buffer. The block accepts or refuses the packet one cycle later and names the buffer it has reserved.

When the packet completes, the block files a descriptor in an eight-entry receive queue and retires the buffer from its pool. A descriptor holds the buffer ID, a SETUP/OUT flag and a byte count from 0 to 64. Software later pops the descriptor to locate the stored data. If the packet is dropped because of an error, the buffer stays at the front of its pool, so the next packet of that kind reuses it.

One receive-queue slot is always kept back for SETUP traffic. This means that a flood of OUT data can never shut out a control request. The block also reports pool and queue occupancy, keeps a sticky pool-overflow flag, and produces single-cycle pulses when a pool runs dry or the receive queue fills while the interface is enabled.

Top module: `pbq_top`

## Requirements
- R1: After reset, all three queues report an occupancy of zero, `rx_valid`, `gnt_ack`, `gnt_nak`, `av_ovf` and `ev_rx_full` are 0, and `out_av_cnt`, `setup_av_cnt` and `rx_cnt` are 0.
- R2: A push strobe into a pool that is not full adds the ID, and the occupancy count reflects it one cycle later. Each pool hands IDs out in the order in which they were pushed.
- R3: Consider a `pkt_start` with `pkt_setup`=0 while no packet is in flight. If the OUT pool is not empty and `rx_cnt` is below RX_DEPTH-1, a single-cycle `gnt_ack` pulse follows one cycle later, with `gnt_id` equal to the ID at the front of the OUT pool.
- R4: An OUT start while the OUT pool is empty gives a single-cycle `gnt_nak` one cycle later, and no counts change.
- R5: When `rx_cnt` equals RX_DEPTH-1 (7), an OUT start is refused with `gnt_nak` and `rx_cnt` stays at 7.
- R6: A SETUP start (`pkt_setup`=1) takes its ID from the SETUP pool. It is accepted while `rx_cnt` is below RX_DEPTH, so it may fill the eighth slot. It is refused when the SETUP pool is empty or `rx_cnt` equals RX_DEPTH.
- R7: `pkt_done` for an accepted packet does two things one cycle later: it adds one to `rx_cnt` and removes one from the source pool's count. The new descriptor carries the granted ID, `rx_setup`=1 for SETUP and 0 for OUT, and `rx_len` equal to `pkt_len`.
- R8: `pkt_abort` for an accepted packet leaves every count unchanged. The next start of the same kind is granted the same ID again.
- R9: A push into a full pool is dropped, and `av_ovf` is set one cycle later. `av_ovf` stays set until `av_ovf_clr` is strobed.
- R10: `ev_av_empty` pulses for exactly one cycle, one cycle after the condition (`en` high and either pool empty) becomes true.
- R11: `ev_rx_full` pulses for exactly one cycle, one cycle after `rx_cnt` reaches RX_DEPTH while `en` is high.
- R12: `rx_pop` removes the head descriptor. Descriptors leave in the order in which their packets completed, and the head fields (`rx_id`, `rx_setup`, `rx_len`) are valid whenever `rx_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enabled; qualifies the event pulses |
| out_av_push | input | 1 | Push strobe into the OUT buffer pool |
| out_av_id | input | 5 | Buffer ID to push into the OUT pool |
| setup_av_push | input | 1 | Push strobe into the SETUP buffer pool |
| setup_av_id | input | 5 | Buffer ID to push into the SETUP pool |
| av_ovf_clr | input | 1 | Clears the sticky overflow flag |
| pkt_start | input | 1 | A packet has begun arriving |
| pkt_setup | input | 1 | Kind of the starting packet: 1 SETUP, 0 OUT |
| pkt_done | input | 1 | The in-flight packet completed correctly |
| pkt_abort | input | 1 | The in-flight packet was dropped |
| pkt_len | input | 7 | Byte count of the completed packet (0 to 64) |
| gnt_ack | output | 1 | Packet accepted (one-cycle pulse) |
| gnt_nak | output | 1 | Packet refused (one-cycle pulse) |
| gnt_id | output | 5 | Buffer ID reserved for the accepted packet |
| rx_pop | input | 1 | Pop strobe for the receive queue |
| rx_valid | output | 1 | Receive queue holds a descriptor |
| rx_id | output | 5 | Head descriptor buffer ID |
| rx_setup | output | 1 | Head descriptor kind: 1 SETUP, 0 OUT |
| rx_len | output | 7 | Head descriptor byte count |
| out_av_cnt | output | 4 | OUT pool occupancy |
| setup_av_cnt | output | 3 | SETUP pool occupancy |
| rx_cnt | output | 4 | Receive queue occupancy |
| av_ovf | output | 1 | Sticky pool overflow flag |
| ev_av_empty | output | 1 | Pulse: a pool became empty while enabled |
| ev_rx_full | output | 1 | Pulse: receive queue became full while enabled |

## Verification
Grants appear one clock edge after `pkt_start`. Count changes and the new head descriptor appear one edge after the push, pop, done or abort strobe that causes them. The two event pulses come one edge after that, because they register the edge of a condition that is itself built from registered counts. The bench drives each strobe for one cycle on a falling edge and samples on the next falling edge for grants and counts, and on the falling edge after that for events. A scoreboard queue records every descriptor that should have been filed, and each receive-queue pop is compared against the front of that queue.

// File: rtl/pbq_pkg.sv
package pbq_pkg;
  localparam int ID_W  = 5;
  localparam int LEN_W = 7;

  typedef logic [ID_W-1:0] buf_id_t;

  typedef struct packed {
    buf_id_t          id;
    logic             setup;
    logic [LEN_W-1:0] len;
  } rx_desc_t;
endpackage

// File: rtl/pbq_fifo.sv
// Synchronous FIFO. DEPTH must be a power of two; storage has no reset so it maps to RAM.
module pbq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: occupancy never exceeds the depth
  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R9: a push into a full FIFO without a pop leaves occupancy unchanged
  p_full_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/pbq_admit.sv
// Accept/refuse decision and in-flight buffer reservation.
module pbq_admit
  import pbq_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  localparam int RCW     = $clog2(RX_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           setup,
  input  logic           done,
  input  logic           abort,
  input  logic           out_avail,
  input  logic           setup_avail,
  input  buf_id_t        out_head,
  input  buf_id_t        setup_head,
  input  logic [RCW-1:0] rx_cnt,
  output logic           gnt_ack,
  output logic           gnt_nak,
  output buf_id_t        gnt_id,
  output logic           busy,
  output logic           kind_setup,
  output logic           commit
);
  logic room_out, room_setup, ok;

  // Last receive slot is kept back for SETUP traffic.
  assign room_out   = rx_cnt < RCW'(RX_DEPTH - 1);
  assign room_setup = rx_cnt < RCW'(RX_DEPTH);
  assign ok         = setup ? (setup_avail && room_setup) : (out_avail && room_out);
  assign commit     = busy && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      kind_setup <= 1'b0;
      gnt_ack    <= 1'b0;
      gnt_nak    <= 1'b0;
      gnt_id     <= '0;
    end else begin
      gnt_ack <= 1'b0;
      gnt_nak <= 1'b0;
      if (busy) begin
        if (done || abort) busy <= 1'b0;
      end else if (start) begin
        busy       <= ok;
        kind_setup <= setup;
        gnt_ack    <= ok;
        gnt_nak    <= !ok;
        if (ok) gnt_id <= setup ? setup_head : out_head;
      end
    end
  end

  // R3: accept and refuse are never given together
  p_grant_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(gnt_ack && gnt_nak));
  // R3: a grant always answers a start one cycle earlier
  p_grant_after_start_r3: assert property (@(posedge clk) disable iff (rst)
    (gnt_ack || gnt_nak) |-> $past(start));
  // R5: an accepted OUT packet found the reserved slot still free
  p_reserve_r5: assert property (@(posedge clk) disable iff (rst)
    (gnt_ack && !kind_setup) |-> ($past(rx_cnt) < RCW'(RX_DEPTH - 1)));
  // R8: an abort releases the in-flight reservation
  p_abort_release_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && abort) |=> !busy);
endmodule

// File: rtl/pbq_top.sv
module pbq_top
  import pbq_pkg::*;
#(
  parameter int OUT_DEPTH   = 8,
  parameter int SETUP_DEPTH = 4,
  parameter int RX_DEPTH    = 8,
  localparam int OCW        = $clog2(OUT_DEPTH + 1),
  localparam int SCW        = $clog2(SETUP_DEPTH + 1),
  localparam int RCW        = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             out_av_push,
  input  logic [ID_W-1:0]  out_av_id,
  input  logic             setup_av_push,
  input  logic [ID_W-1:0]  setup_av_id,
  input  logic             av_ovf_clr,
  input  logic             pkt_start,
  input  logic             pkt_setup,
  input  logic             pkt_done,
  input  logic             pkt_abort,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             gnt_ack,
  output logic             gnt_nak,
  output logic [ID_W-1:0]  gnt_id,
  input  logic             rx_pop,
  output logic             rx_valid,
  output logic [ID_W-1:0]  rx_id,
  output logic             rx_setup,
  output logic [LEN_W-1:0] rx_len,
  output logic [OCW-1:0]   out_av_cnt,
  output logic [SCW-1:0]   setup_av_cnt,
  output logic [RCW-1:0]   rx_cnt,
  output logic             av_ovf,
  output logic             ev_av_empty,
  output logic             ev_rx_full
);
  buf_id_t  out_head, setup_head;
  logic     out_full, out_empty, setup_full, setup_empty, rx_full, rx_empty;
  logic     busy, kind_setup, commit;
  rx_desc_t new_desc, head_desc;
  logic     empty_cond, empty_q, full_cond, full_q;

  pbq_fifo #(.W(ID_W), .DEPTH(OUT_DEPTH)) u_out_pool (
    .clk(clk), .rst(rst), .push(out_av_push), .din(out_av_id),
    .pop(commit && !kind_setup), .dout(out_head), .count(out_av_cnt),
    .full(out_full), .empty(out_empty));

  pbq_fifo #(.W(ID_W), .DEPTH(SETUP_DEPTH)) u_setup_pool (
    .clk(clk), .rst(rst), .push(setup_av_push), .din(setup_av_id),
    .pop(commit && kind_setup), .dout(setup_head), .count(setup_av_cnt),
    .full(setup_full), .empty(setup_empty));

  pbq_admit #(.RX_DEPTH(RX_DEPTH)) u_admit (
    .clk(clk), .rst(rst), .start(pkt_start), .setup(pkt_setup),
    .done(pkt_done), .abort(pkt_abort), .out_avail(!out_empty),
    .setup_avail(!setup_empty), .out_head(out_head), .setup_head(setup_head),
    .rx_cnt(rx_cnt), .gnt_ack(gnt_ack), .gnt_nak(gnt_nak), .gnt_id(gnt_id),
    .busy(busy), .kind_setup(kind_setup), .commit(commit));

  assign new_desc = '{id: gnt_id, setup: kind_setup, len: pkt_len};

  pbq_fifo #(.W($bits(rx_desc_t)), .DEPTH(RX_DEPTH)) u_rx_queue (
    .clk(clk), .rst(rst), .push(commit), .din(new_desc),
    .pop(rx_pop), .dout(head_desc), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty));

  assign rx_valid = !rx_empty;
  assign rx_id    = head_desc.id;
  assign rx_setup = head_desc.setup;
  assign rx_len   = head_desc.len;

  assign empty_cond = en && (out_empty || setup_empty);
  assign full_cond  = en && rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      av_ovf      <= 1'b0;
      empty_q     <= 1'b0;
      full_q      <= 1'b0;
      ev_av_empty <= 1'b0;
      ev_rx_full  <= 1'b0;
    end else begin
      if ((out_av_push && out_full) || (setup_av_push && setup_full))
        av_ovf <= 1'b1;
      else if (av_ovf_clr)
        av_ovf <= 1'b0;
      empty_q     <= empty_cond;
      full_q      <= full_cond;
      ev_av_empty <= empty_cond && !empty_q;
      ev_rx_full  <= full_cond && !full_q;
    end
  end

  // R9: overflow flag holds until cleared
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (av_ovf && !av_ovf_clr) |=> av_ovf);
  // R11: the full event is a single-cycle pulse
  p_full_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    ev_rx_full |=> !ev_rx_full);
  // R7: a completion always lands in the receive queue
  p_commit_room_r7: assert property (@(posedge clk) disable iff (rst)
    commit |-> !rx_full);
endmodule

// File: tb/pbq_top_tb.sv
module pbq_top_tb;
  import pbq_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic out_av_push = 1'b0, setup_av_push = 1'b0, av_ovf_clr = 1'b0;
  logic [ID_W-1:0] out_av_id = '0, setup_av_id = '0;
  logic pkt_start = 1'b0, pkt_setup = 1'b0, pkt_done = 1'b0, pkt_abort = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic gnt_ack, gnt_nak, rx_pop = 1'b0, rx_valid, rx_setup, av_ovf, ev_av_empty, ev_rx_full;
  logic [ID_W-1:0] gnt_id, rx_id;
  logic [LEN_W-1:0] rx_len;
  logic [3:0] out_av_cnt, rx_cnt;
  logic [2:0] setup_av_cnt;

  int checks = 0, errors = 0;
  rx_desc_t exp_q[$];
  int last_id;

  always #2 clk = ~clk;

  pbq_top u_dut (
    .clk(clk), .rst(rst), .en(en), .out_av_push(out_av_push), .out_av_id(out_av_id),
    .setup_av_push(setup_av_push), .setup_av_id(setup_av_id), .av_ovf_clr(av_ovf_clr),
    .pkt_start(pkt_start), .pkt_setup(pkt_setup), .pkt_done(pkt_done),
    .pkt_abort(pkt_abort), .pkt_len(pkt_len), .gnt_ack(gnt_ack), .gnt_nak(gnt_nak),
    .gnt_id(gnt_id), .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_id(rx_id),
    .rx_setup(rx_setup), .rx_len(rx_len), .out_av_cnt(out_av_cnt),
    .setup_av_cnt(setup_av_cnt), .rx_cnt(rx_cnt), .av_ovf(av_ovf),
    .ev_av_empty(ev_av_empty), .ev_rx_full(ev_rx_full));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_out(input int id);
    out_av_push = 1'b1; out_av_id = ID_W'(id);
    tick();
    out_av_push = 1'b0;
  endtask

  task automatic push_setup(input int id);
    setup_av_push = 1'b1; setup_av_id = ID_W'(id);
    tick();
    setup_av_push = 1'b0;
  endtask

  // Start a packet; returns 1 for ack, 0 for nak, and the granted ID.
  task automatic start(input bit is_setup, output bit acked, output int id);
    pkt_start = 1'b1; pkt_setup = is_setup;
    tick();
    pkt_start = 1'b0;
    acked = gnt_ack;
    id = gnt_id;
    chk(gnt_ack ^ gnt_nak, "R3 one grant pulse", gnt_ack + gnt_nak, 1);
  endtask

  // Driver side of the scoreboard: completion files an expected descriptor.
  task automatic finish(input bit is_setup, input int id, input int len);
    pkt_done = 1'b1; pkt_len = LEN_W'(len);
    exp_q.push_back('{id: ID_W'(id), setup: is_setup, len: LEN_W'(len)});
    tick();
    pkt_done = 1'b0;
  endtask

  // Monitor side of the scoreboard: compare head with the oldest expectation, then pop.
  task automatic pop_check();
    rx_desc_t e;
    e = exp_q.pop_front();
    chk(rx_valid, "R12 valid", rx_valid, 1);
    chk(rx_id == e.id, "R7 id", rx_id, e.id);
    chk(rx_setup == e.setup, "R7 kind", rx_setup, e.setup);
    chk(rx_len == e.len, "R7 len", rx_len, e.len);
    rx_pop = 1'b1;
    tick();
    rx_pop = 1'b0;
  endtask

  initial begin
    bit a;
    int id;
    int lens [7] = '{64, 0, 5, 17, 1, 63, 32};
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1
    chk(rx_cnt == 0 && out_av_cnt == 0 && setup_av_cnt == 0, "R1 counts", rx_cnt, 0);
    chk(!rx_valid && !gnt_ack && !gnt_nak && !av_ovf, "R1 flags", rx_valid, 0);

    // R10: enabling with empty pools gives one pulse
    en = 1'b1;
    tick();
    chk(ev_av_empty == 1'b1, "R10 pulse", ev_av_empty, 1);
    tick();
    chk(ev_av_empty == 1'b0, "R10 single", ev_av_empty, 0);

    // R4: OUT with an empty pool
    start(1'b0, a, id);
    chk(a == 1'b0, "R4 nak empty", a, 0);

    // R2 / R9
    for (int i = 1; i <= 8; i++) push_out(i);
    chk(out_av_cnt == 8, "R2 count", out_av_cnt, 8);
    chk(av_ovf == 1'b0, "R9 no ovf yet", av_ovf, 0);
    push_out(30);
    chk(av_ovf == 1'b1, "R9 ovf set", av_ovf, 1);
    chk(out_av_cnt == 8, "R9 dropped", out_av_cnt, 8);
    tick();
    chk(av_ovf == 1'b1, "R9 sticky", av_ovf, 1);
    av_ovf_clr = 1'b1; tick(); av_ovf_clr = 1'b0;
    chk(av_ovf == 1'b0, "R9 cleared", av_ovf, 0);
    push_setup(20);
    push_setup(21);
    chk(setup_av_cnt == 2, "R2 setup count", setup_av_cnt, 2);

    // R3 / R7: seven OUT packets in pool order
    for (int i = 0; i < 7; i++) begin
      start(1'b0, a, id);
      chk(a == 1'b1, "R3 ack", a, 1);
      chk(id == i + 1, "R3 id order", id, i + 1);
      finish(1'b0, id, lens[i]);
      chk(rx_cnt == 4'(i + 1), "R7 rx count", rx_cnt, i + 1);
      chk(out_av_cnt == 4'(7 - i), "R7 pool count", out_av_cnt, 7 - i);
    end

    // R5: reserved slot refuses OUT
    start(1'b0, a, id);
    chk(a == 1'b0, "R5 nak reserved", a, 0);
    chk(rx_cnt == 7, "R5 count stays", rx_cnt, 7);

    // R6: SETUP takes the last slot
    start(1'b1, a, id);
    chk(a == 1'b1 && id == 20, "R6 setup ack", id, 20);
    finish(1'b1, id, 8);
    chk(rx_cnt == 8, "R6 rx full", rx_cnt, 8);
    chk(setup_av_cnt == 1, "R7 setup pool", setup_av_cnt, 1);
    tick();
    chk(ev_rx_full == 1'b1, "R11 pulse", ev_rx_full, 1);
    tick();
    chk(ev_rx_full == 1'b0, "R11 single", ev_rx_full, 0);
    start(1'b1, a, id);
    chk(a == 1'b0, "R6 setup nak full", a, 0);

    // R12: drain in order
    for (int i = 0; i < 8; i++) pop_check();
    chk(rx_valid == 1'b0 && rx_cnt == 0, "R12 drained", rx_cnt, 0);

    // R8: abort keeps the buffer at the front
    start(1'b0, a, id);
    chk(a == 1'b1 && id == 8, "R8 first grant", id, 8);
    pkt_abort = 1'b1; tick(); pkt_abort = 1'b0;
    chk(out_av_cnt == 1 && rx_cnt == 0, "R8 counts kept", out_av_cnt, 1);
    start(1'b0, a, id);
    last_id = id;
    chk(a == 1'b1 && last_id == 8, "R8 same id", last_id, 8);
    finish(1'b0, id, 12);
    tick();
    chk(ev_av_empty == 1'b1, "R10 pool dry", ev_av_empty, 1);
    start(1'b0, a, id);
    chk(a == 1'b0, "R4 nak after drain", a, 0);
    pop_check();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule